// File: doc/BRIEF.md
# Power-On and Hard Reset Sequencer

This block runs the chip-level reset flow. A power-on reset request counts only once it has been held low for a minimum number of clock cycles. While it is held, the block samples the configuration-source pins and keeps the last value it saw. When the request ends, the block waits a fixed number of cycles. It then asks a configuration-word loader to run and waits, for as long as needed, until the loader reports that it is done. Through the whole flow the block pulls the shared open-drain hard reset line low.

After the loader reports done, the block lets go of the line, which an external pull-up returns high. Once the line is seen high, the block ignores it for a blanking window. It then enters the run state, where the rest of the chip may operate. In the run state, either an internal hard reset request or a low level on the line starts a hard reset. A hard reset goes straight to the load request and reuses the source value captured at power-on. The pins are never sampled again during a hard reset.

The line is modelled as two signals: a pull-down enable output and a sensed-level input. The level outside the block is low if anyone pulls the line down and high otherwise.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While rst_ni is low and afterwards, until a qualified power-on reset has come and gone, the block has these outputs. state_o is 0 (power-on wait), hrst_drive_o is 1, run_o is 0, ld_req_o is 0 and cfg_src_o is 0.
- R2: A power-on reset qualifies only if por_ni is sampled low on 32 consecutive rising edges. A low pulse of 31 edges or fewer changes no output, state or latched value.
- R3: cfg_src_o takes the value of cfg_src_i sampled on the last edge of a qualified power-on reset. Changes on cfg_src_i at any other time, including during a hard reset, leave cfg_src_o unchanged.
- R4: state_o becomes 1 (delay) on the first edge that samples por_ni high after a qualified power-on reset. ld_req_o rises and state_o becomes 2 (load) exactly 150 edges later.
- R5: In states 2 (load) and 3 (hard reset load), ld_req_o stays high for any number of cycles until ld_done_i is sampled high.
- R6: hrst_drive_o is 1 in states 0 to 3 and 0 in states 4 (blanking) and 5 (run).
- R7: An edge that samples ld_done_i high in state 2 or 3 moves the block to state 4. The block stays in state 4 until the line has been sampled high once, and then for 16 more edges, after which it enters state 5. A low line in that window has no effect.
- R8: A low hrst_line_i sampled in state 5 moves the block to state 3 on that edge, with ld_req_o high and no delay phase.
- R9: int_hrst_req_i sampled high in state 5 moves the block to state 3. In any other state it has no effect.
- R10: A qualified power-on reset returns the block to state 0 from any state, with hrst_drive_o 1 and ld_req_o 0.
- R11: run_o is 1 exactly when state_o is 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Stable input clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block's flops |
| por_ni | input | 1 | Power-on reset request, active low, qualified by length |
| cfg_src_i | input | SRC_W | Configuration-source pins |
| int_hrst_req_i | input | 1 | Internal hard reset request |
| hrst_line_i | input | 1 | Sensed level of the open-drain hard reset line |
| hrst_drive_o | output | 1 | 1 pulls the hard reset line low |
| ld_req_o | output | 1 | Request to the configuration-word loader |
| ld_done_i | input | 1 | Loader completion |
| cfg_src_o | output | SRC_W | Source value latched at power-on |
| state_o | output | 3 | Sequencer state (0 to 5) |
| run_o | output | 1 | High only in the run state |

## Verification
Every result appears on the rising edge that samples its cause. Power-on qualification appears on the 32nd low edge, the load request 150 edges after the delay starts, and run 17 edges after the blanking state is entered when the line is already high. The bench drives inputs 1 ns after a rising edge and steps a counted number of edges before it reads the outputs, at the same offset. Each check therefore sits on the exact edge where a value must change and on the edge just before it, so an off-by-one counter shows up.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [2:0] {
    ST_PORW  = 3'd0,
    ST_DELAY = 3'd1,
    ST_LOAD  = 3'd2,
    ST_HRST  = 3'd3,
    ST_BLANK = 3'd4,
    ST_RUN   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/rsq_por_filter.sv
module rsq_por_filter #(
  parameter int unsigned MIN_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_ni,
  output logic qual_o
);
  localparam int unsigned CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (por_ni)      cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  // saturates, so a held request keeps re-qualifying
  assign qual_o = !por_ni && (cnt_q == LAST);
endmodule

// File: rtl/rsq_timer.sv
module rsq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
  import rst_seq_pkg::*;
#(
  parameter int unsigned SRC_W     = 3,
  parameter int unsigned DLY_CYC   = 150,
  parameter int unsigned BLANK_CYC = 16,
  parameter int unsigned TW        = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_qual_i,
  input  logic             por_ni,
  input  logic             line_i,
  input  logic             int_req_i,
  input  logic             ld_done_i,
  input  logic [SRC_W-1:0] cfg_src_i,
  input  logic [TW-1:0]    cnt_i,
  output seq_state_e       state_o,
  output logic             tmr_clr_o,
  output logic             tmr_en_o,
  output logic [SRC_W-1:0] cfg_src_o
);
  localparam logic [TW-1:0] DLY_LAST = TW'(DLY_CYC - 1);
  localparam logic [TW-1:0] BLK_LAST = TW'(BLANK_CYC - 1);

  seq_state_e st_q, st_n;
  logic       armed_q;
  logic       seen_q;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_PORW:  if (armed_q && por_ni) st_n = ST_DELAY;
      ST_DELAY: if (cnt_i == DLY_LAST) st_n = ST_LOAD;
      ST_LOAD,
      ST_HRST:  if (ld_done_i) st_n = ST_BLANK;
      ST_BLANK: if (seen_q && cnt_i == BLK_LAST) st_n = ST_RUN;
      ST_RUN:   if (!line_i || int_req_i) st_n = ST_HRST;
      default:  st_n = ST_PORW;
    endcase
    if (por_qual_i) st_n = ST_PORW;
  end

  assign tmr_clr_o = (st_n != st_q);
  assign tmr_en_o  = (st_q == ST_DELAY) || (st_q == ST_BLANK && seen_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_PORW;
      armed_q   <= 1'b0;
      seen_q    <= 1'b0;
      cfg_src_o <= '0;
    end else begin
      st_q    <= st_n;
      armed_q <= por_qual_i || (armed_q && st_n == ST_PORW);
      // blanking starts at the first high level after release
      seen_q  <= (st_n == ST_BLANK) && (seen_q || (st_q == ST_BLANK && line_i));
      if (por_qual_i) cfg_src_o <= cfg_src_i;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int unsigned SRC_W     = 3,
  parameter int unsigned POR_MIN   = 32,
  parameter int unsigned DLY_CYC   = 150,
  parameter int unsigned BLANK_CYC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic [SRC_W-1:0] cfg_src_i,
  input  logic             int_hrst_req_i,
  input  logic             hrst_line_i,
  output logic             hrst_drive_o,
  output logic             ld_req_o,
  input  logic             ld_done_i,
  output logic [SRC_W-1:0] cfg_src_o,
  output logic [2:0]       state_o,
  output logic             run_o
);
  localparam int unsigned MAXC = (DLY_CYC > BLANK_CYC) ? DLY_CYC : BLANK_CYC;
  localparam int unsigned TW   = $clog2(MAXC + 1);

  logic          por_qual;
  logic          tmr_clr, tmr_en;
  logic [TW-1:0] tmr_cnt;
  seq_state_e    st;

  rsq_por_filter #(.MIN_CYC(POR_MIN)) u_por (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .por_ni (por_ni),
    .qual_o (por_qual)
  );

  rsq_timer #(.W(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .en_i   (tmr_en),
    .cnt_o  (tmr_cnt)
  );

  rsq_fsm #(
    .SRC_W     (SRC_W),
    .DLY_CYC   (DLY_CYC),
    .BLANK_CYC (BLANK_CYC),
    .TW        (TW)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .por_qual_i (por_qual),
    .por_ni     (por_ni),
    .line_i     (hrst_line_i),
    .int_req_i  (int_hrst_req_i),
    .ld_done_i  (ld_done_i),
    .cfg_src_i  (cfg_src_i),
    .cnt_i      (tmr_cnt),
    .state_o    (st),
    .tmr_clr_o  (tmr_clr),
    .tmr_en_o   (tmr_en),
    .cfg_src_o  (cfg_src_o)
  );

  assign state_o      = st;
  assign run_o        = (st == ST_RUN);
  assign ld_req_o     = (st == ST_LOAD) || (st == ST_HRST);
  assign hrst_drive_o = (st == ST_PORW) || (st == ST_DELAY) || ld_req_o;
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker
  import rst_seq_pkg::*;
#(
  parameter int unsigned SRC_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             por_ni,
  input logic             int_hrst_req_i,
  input logic             hrst_line_i,
  input logic             hrst_drive_o,
  input logic             ld_req_o,
  input logic             ld_done_i,
  input logic [SRC_W-1:0] cfg_src_o,
  input logic [2:0]       state_o,
  input logic             run_o
);
  a_r6_run_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> !hrst_drive_o);

  a_r5_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_req_o && !ld_done_i && por_ni) |=> ld_req_o);

  a_r3_hrst_keeps_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_HRST) |-> $stable(cfg_src_o));

  a_r8_line_low_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !hrst_line_i && por_ni) |=> (state_o == ST_HRST));

  a_r9_req_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && int_hrst_req_i && por_ni) |=> (state_o == ST_HRST));

  a_r7_run_after_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> ($past(state_o) == ST_BLANK));
endmodule

bind rst_seq_ctrl rsq_checker #(.SRC_W(SRC_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .por_ni         (por_ni),
  .int_hrst_req_i (int_hrst_req_i),
  .hrst_line_i    (hrst_line_i),
  .hrst_drive_o   (hrst_drive_o),
  .ld_req_o       (ld_req_o),
  .ld_done_i      (ld_done_i),
  .cfg_src_o      (cfg_src_o),
  .state_o        (state_o),
  .run_o          (run_o)
);

// File: tb/tb_rst_seq_ctrl.sv
`timescale 1ns/1ps
module tb_rst_seq_ctrl;
  localparam int SRC_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_n = 1'b1;
  logic [SRC_W-1:0] cfg = '0;
  logic int_req = 1'b0;
  logic ext_low = 1'b0;
  logic ld_done = 1'b0;
  logic drive, ld_req, run, line;
  logic [SRC_W-1:0] cfg_o;
  logic [2:0] st;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  // open-drain line with pull-up
  assign line = !(drive || ext_low);

  rst_seq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .cfg_src_i(cfg),
    .int_hrst_req_i(int_req), .hrst_line_i(line), .hrst_drive_o(drive),
    .ld_req_o(ld_req), .ld_done_i(ld_done), .cfg_src_o(cfg_o),
    .state_o(st), .run_o(run)
  );

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // ld_done pulse, blanking with line high, then run
  task automatic finish_load(input string req);
    ld_done = 1'b1; tick(1); ld_done = 1'b0;
    chk("R7", {req, " blank entered"}, st, 4);
    chk("R6", "released in blank", drive, 0);
    tick(16);
    chk("R7", {req, " still blank"}, st, 4);
    tick(1);
    chk("R7", {req, " run"}, st, 5);
    chk("R11", "run_o in run", run, 1);
  endtask

  task automatic full_delay_load;
    chk("R4", "delay entered", st, 1);
    tick(149);
    chk("R4", "no req before 150", ld_req, 0);
    chk("R6", "drive in delay", drive, 1);
    tick(1);
    chk("R4", "load state", st, 2);
    chk("R4", "req at 150", ld_req, 1);
  endtask

  task automatic t_reset;
    tick(3); rst_n = 1'b1; tick(5);
    chk("R1", "state", st, 0);
    chk("R1", "drive", drive, 1);
    chk("R1", "run", run, 0);
    chk("R1", "ld_req", ld_req, 0);
    chk("R1", "cfg", cfg_o, 0);
  endtask

  task automatic t_power_on;
    por_n = 1'b0; cfg = 3'd5; tick(31);
    cfg = 3'd3; tick(3);
    por_n = 1'b1; tick(1);
    chk("R3", "cfg latched", cfg_o, 3);
    cfg = 3'd1;
    full_delay_load();
    tick(40);
    chk("R5", "req held", ld_req, 1);
    chk("R6", "drive in load", drive, 1);
    // blanking with a low pulse on the line after it was seen high
    ld_done = 1'b1; tick(1); ld_done = 1'b0;
    chk("R7", "blank", st, 4);
    tick(3); ext_low = 1'b1; tick(3);
    chk("R7", "low ignored in blank", st, 4);
    ext_low = 1'b0; tick(10);
    chk("R7", "blank end-1", st, 4);
    tick(1);
    chk("R7", "run after window", st, 5);
    chk("R11", "run_o", run, 1);
    chk("R3", "pins changed after por", cfg_o, 3);
  endtask

  task automatic t_int_req;
    cfg = 3'd6; int_req = 1'b1; tick(1);
    chk("R9", "hrst from run", st, 3);
    chk("R8", "req no delay", ld_req, 1);
    chk("R6", "drive in hrst", drive, 1);
    chk("R11", "run_o low", run, 0);
    tick(2);
    chk("R9", "ignored in hrst", st, 3);
    int_req = 1'b0; tick(20);
    chk("R5", "hrst waits", ld_req, 1);
    chk("R3", "not resampled", cfg_o, 3);
    ld_done = 1'b1; tick(1); ld_done = 1'b0;
    int_req = 1'b1; tick(5);
    chk("R9", "ignored in blank", st, 4);
    int_req = 1'b0; tick(11);
    chk("R9", "blank timing kept", st, 4);
    tick(1);
    chk("R9", "run", st, 5);
  endtask

  task automatic t_ext;
    ext_low = 1'b1; tick(1);
    chk("R8", "ext low -> hrst", st, 3);
    chk("R8", "ld_req", ld_req, 1);
    ld_done = 1'b1; tick(1); ld_done = 1'b0;
    chk("R7", "blank with line held", st, 4);
    tick(4);
    chk("R7", "waits for high", st, 4);
    ext_low = 1'b0; tick(16);
    chk("R7", "window from high", st, 4);
    tick(1);
    chk("R7", "run", st, 5);
  endtask

  task automatic t_short_por;
    por_n = 1'b0; cfg = 3'd2; tick(31);
    por_n = 1'b1; tick(3);
    chk("R2", "short pulse state", st, 5);
    chk("R2", "short pulse run", run, 1);
    chk("R2", "short pulse cfg", cfg_o, 3);
  endtask

  task automatic t_abort;
    por_n = 1'b0; cfg = 3'd2; tick(31);
    chk("R2", "31 edges not yet", st, 5);
    tick(1);
    chk("R10", "abort from run", st, 0);
    chk("R10", "drive", drive, 1);
    chk("R10", "ld_req", ld_req, 0);
    por_n = 1'b1; tick(1);
    chk("R3", "new cfg", cfg_o, 2);
    tick(50);
    por_n = 1'b0; cfg = 3'd7; tick(32);
    chk("R10", "abort from delay", st, 0);
    chk("R3", "cfg recaptured", cfg_o, 7);
    por_n = 1'b1; tick(1);
    full_delay_load();
    tick(7);
    por_n = 1'b0; tick(32);
    chk("R10", "abort from load", st, 0);
    chk("R10", "ld_req dropped", ld_req, 0);
    por_n = 1'b1; tick(1);
    full_delay_load();
    finish_load("final");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_power_on();
    t_int_req();
    t_ext();
    t_short_por();
    t_abort();
    summary();
    $finish;
  end
endmodule